// File: doc/BRIEF.md
# Syndrome-Trellis Hard-Decision Viterbi Decoder

This block decodes a rate-3/4 convolutional code by running the Viterbi search over the trellis of the code's parity-check circuit instead of over the encoder trellis. It takes a 4-bit received symbol per code interval. The usual caller feeds it the residue sequence left after a predecode and re-encode step, but any 4-bit code sequence can be given. Each interval is walked as four serial trellis stages, one per code bit and one per clock. The trellis has eight states. Because a single code bit either keeps the state or flips it by a fixed mask, every node has exactly two candidate predecessors, so each stage needs only eight two-way add-compare-select cells.

Every state keeps a saturating Hamming metric and a register-exchange survivor. The survivor holds the branch bits of `LEN_INT` intervals. After each interval the metrics are rebased, and the oldest symbol of the best survivor is presented as the estimated code symbol. The last three bits of that symbol are also presented as the information-error word of the systematic code.

Top module: `sft_decoder`

## Requirements
- R1: A synchronous active-high reset drives out_valid, out_err and out_info to zero and clears every survivor. It starts the search with state 0 at metric 0 and every other state at the saturated metric.
- R2: The symbol on in_sym is taken on a clock edge where in_valid is high. Bit 0 is code bit 1, the check bit, and bits 1 to 3 are code bits 2 to 4. Symbols may be spaced 4 or more cycles apart, and the decoded values do not depend on the spacing.
- R3: out_valid is a single-cycle pulse. It rises exactly 5 cycles after the edge that took a symbol and at no other time.
- R4: A code sequence without errors is given back unchanged, LEN_INT-1 intervals late. In such a sequence the check bit equals (1+D)·b2 + (1+D²)·b3 + (1+D+D²)·b4 over the code bits b2..b4, with a zero history at reset.
- R5: A single flipped bit is removed from the output when at least LEN_INT error-free intervals lie on each side of it.
- R6: The search is a hard-decision Viterbi search on states {s2,s1,s0}. s0 is the running parity of the current check. s1 and s2 are the carries into the next check and the one after. At code bit j (j = 1..4), a branch bit of 1 XORs the state with {t2,t1,1}. t1 is set for code bits 2 and 4, and t2 for code bits 3 and 4. The branch cost is 1 when the branch bit differs from the received bit and 0 otherwise. When the two sums are equal, the lower-numbered predecessor wins.
- R7: At each interval end, paths whose s0 is 1 are dropped. The state then moves down one place (s1 to s0, s2 to s1, s2 cleared), and states with s2 set take the saturated metric.
- R8: Metrics are MW-bit counts that stop at all ones. After each interval, the smallest metric is subtracted from every metric that is not saturated.
- R9: out_err is the oldest symbol of the survivor of the lowest-numbered state with the smallest metric, with bit j holding code bit j+1. out_info equals out_err bits 3..1.
- R10: The first LEN_INT-1 results after a reset are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe for in_sym |
| in_sym | input | 4 | Received symbol, check bit in bit 0 |
| out_valid | output | 1 | One-cycle strobe for the decoded symbol |
| out_err | output | 4 | Decoded code symbol from LEN_INT-1 intervals earlier |
| out_info | output | 3 | Information bits of out_err (bits 3..1) |

## Verification
Each accepted symbol produces its strobe 5 cycles after the edge that took it: one latch cycle, four stage cycles with the interval close folded into the last one, then the output register. The bench records that due cycle for every symbol it drives. It samples on the falling edge of exactly that cycle and flags a strobe in any other cycle. The decoded content for an interval comes out LEN_INT-1 intervals later. The bench lines each result up with the symbol it sent that many intervals before. It also compares each result with a behavioural search that runs in step with the same input.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // symbol and trellis geometry of the rate-3/4 code
  localparam int SYM_BITS = 4;
  localparam int ST_BITS  = 3;
  localparam int N_ST     = 1 << ST_BITS;
  localparam int STG_W    = $clog2(SYM_BITS);

  // code-bit columns whose check polynomial has a D or D^2 term
  localparam logic [SYM_BITS-1:0] TAP_D1 = 4'b1010;
  localparam logic [SYM_BITS-1:0] TAP_D2 = 4'b1100;

  // state flip applied when the branch bit at a stage is 1
  function automatic logic [ST_BITS-1:0] flip_mask(input logic [STG_W-1:0] stage);
    return {TAP_D2[stage], TAP_D1[stage], 1'b1};
  endfunction
endpackage

// File: rtl/sft_minfind.sv
module sft_minfind #(
  parameter int MW = 6,
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][MW-1:0] vals,
  output logic [IW-1:0]        idx
);
  logic [MW-1:0] best;

  // strict compare keeps the lowest index among equal minima
  always_comb begin
    best = vals[0];
    idx  = '0;
    for (int i = 1; i < N; i++) begin
      if (vals[i] < best) begin
        best = vals[i];
        idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sft_acs.sv
module sft_acs
  import sft_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic [STG_W-1:0]              stage,
  input  logic                          rbit,
  input  logic [N_ST-1:0][MW-1:0]       pm_in,
  output logic [N_ST-1:0][MW-1:0]       pm_out,
  output logic [N_ST-1:0][ST_BITS-1:0]  pred,
  output logic [N_ST-1:0]               ebit
);
  localparam logic [MW-1:0] SAT = '1;

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic b);
    return (a == SAT) ? SAT : a + MW'(b);
  endfunction

  logic [ST_BITS-1:0] msk;
  assign msk = flip_mask(stage);

  for (genvar t = 0; t < N_ST; t++) begin : g_cell
    localparam logic [ST_BITS-1:0] SELF = ST_BITS'(t);
    logic [ST_BITS-1:0] alt;
    logic [MW-1:0]      c_keep, c_flip;
    logic               take_flip;

    always_comb begin
      alt    = SELF ^ msk;
      c_keep = sat_add(pm_in[SELF], rbit);   // branch bit 0
      c_flip = sat_add(pm_in[alt], ~rbit);   // branch bit 1
      if (c_flip < c_keep)       take_flip = 1'b1;
      else if (c_flip == c_keep) take_flip = (alt < SELF);
      else                       take_flip = 1'b0;
    end

    assign pm_out[t] = take_flip ? c_flip : c_keep;
    assign pred[t]   = take_flip ? alt : SELF;
    assign ebit[t]   = take_flip;
  end
endmodule

// File: rtl/sft_boundary.sv
module sft_boundary
  import sft_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic [N_ST-1:0][MW-1:0] pm_in,
  output logic [N_ST-1:0][MW-1:0] pm_out
);
  localparam logic [MW-1:0] SAT  = '1;
  localparam int            HALF = N_ST / 2;

  logic [N_ST-1:0][MW-1:0] mapped;
  logic [ST_BITS-1:0]      lo_idx;
  logic [MW-1:0]           lo_val;

  // drop odd-parity states, shift the carries down, block the top half
  always_comb begin
    for (int n = 0; n < N_ST; n++) begin
      mapped[n] = (n >= HALF) ? SAT : pm_in[(n % HALF) * 2];
    end
  end

  sft_minfind #(.MW(MW), .N(N_ST)) u_min (
    .vals (mapped),
    .idx  (lo_idx)
  );

  assign lo_val = mapped[lo_idx];

  always_comb begin
    for (int n = 0; n < N_ST; n++) begin
      pm_out[n] = (mapped[n] == SAT) ? SAT : mapped[n] - lo_val;
    end
  end
endmodule

// File: rtl/sft_survivor.sv
module sft_survivor
  import sft_pkg::*;
#(
  parameter int LEN_INT = 12,
  localparam int W = LEN_INT * SYM_BITS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step,
  input  logic                          last,
  input  logic [N_ST-1:0][ST_BITS-1:0]  pred,
  input  logic [N_ST-1:0]               ebit,
  input  logic [ST_BITS-1:0]            rd_sel,
  output logic [SYM_BITS-1:0]           rd_word
);
  localparam int HALF = N_ST / 2;

  logic [W-1:0] sv  [N_ST];
  logic [W-1:0] nxt [N_ST];

  always_comb begin
    for (int t = 0; t < N_ST; t++) begin
      nxt[t] = {sv[pred[t]][W-2:0], ebit[t]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < N_ST; n++) sv[n] <= '0;
    end else if (step) begin
      for (int n = 0; n < N_ST; n++) begin
        sv[n] <= last ? nxt[(n % HALF) * 2] : nxt[n];
      end
    end
  end

  // oldest interval sits at the top, first code bit highest
  always_comb begin
    for (int j = 0; j < SYM_BITS; j++) begin
      rd_word[j] = sv[rd_sel][W-1-j];
    end
  end

  // R10: right after reset the oldest slot of every path is empty
  a_r10_clear_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (rd_word == '0));
endmodule

// File: rtl/sft_decoder.sv
module sft_decoder
  import sft_pkg::*;
#(
  parameter int MW      = 6,
  parameter int LEN_INT = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [3:0]          in_sym,
  output logic                out_valid,
  output logic [3:0]          out_err,
  output logic [2:0]          out_info
);
  localparam logic [MW-1:0]    SAT      = '1;
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(SYM_BITS - 1);

  logic                          run_q;
  logic [STG_W-1:0]              cnt_q;
  logic [SYM_BITS-1:0]           sym_q;
  logic                          done_q;
  logic [N_ST-1:0][MW-1:0]       pm_q;
  logic [N_ST-1:0][MW-1:0]       pm_acs, pm_bnd;
  logic [N_ST-1:0][ST_BITS-1:0]  pred;
  logic [N_ST-1:0]               ebit;
  logic [ST_BITS-1:0]            best_st;
  logic [SYM_BITS-1:0]           rd_word;
  logic                          last_stg;

  assign last_stg = run_q && (cnt_q == LAST_STG);

  sft_acs #(.MW(MW)) u_acs (
    .stage  (cnt_q),
    .rbit   (sym_q[cnt_q]),
    .pm_in  (pm_q),
    .pm_out (pm_acs),
    .pred   (pred),
    .ebit   (ebit)
  );

  sft_boundary #(.MW(MW)) u_bnd (
    .pm_in  (pm_acs),
    .pm_out (pm_bnd)
  );

  sft_survivor #(.LEN_INT(LEN_INT)) u_sv (
    .clk     (clk),
    .rst     (rst),
    .step    (run_q),
    .last    (last_stg),
    .pred    (pred),
    .ebit    (ebit),
    .rd_sel  (best_st),
    .rd_word (rd_word)
  );

  sft_minfind #(.MW(MW), .N(N_ST)) u_best (
    .vals (pm_q),
    .idx  (best_st)
  );

  // stage sequencer and metric store
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sym_q  <= '0;
      done_q <= 1'b0;
      for (int s = 0; s < N_ST; s++) pm_q[s] <= (s == 0) ? '0 : SAT;
    end else begin
      done_q <= last_stg;
      if (run_q) pm_q <= last_stg ? pm_bnd : pm_acs;
      if (in_valid) begin
        sym_q <= in_sym;
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_stg) run_q <= 1'b0;
      end
    end
  end

  // registered result, one cycle after the interval closes
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= '0;
      out_info  <= '0;
    end else begin
      out_valid <= done_q;
      if (done_q) begin
        out_err  <= rd_word;
        out_info <= rd_word[SYM_BITS-1:1];
      end
    end
  end

  // R2: a new symbol only while idle or in the final stage
  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (!run_q || cnt_q == LAST_STG));

  // R3: strobe follows the interval close and lasts one cycle
  a_r3_strobe_after_close: assert property (@(posedge clk) disable iff (rst)
    done_q |=> out_valid);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: rebased metrics put the best state at zero
  a_r8_floor_zero: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (pm_q[best_st] == '0));

  // R7: states with the far carry set are unreachable at a boundary
  for (genvar n = N_ST / 2; n < N_ST; n++) begin : g_chk_top
    a_r7_top_blocked: assert property (@(posedge clk) disable iff (rst)
      done_q |-> (pm_q[n] == SAT));
  end
endmodule

// File: tb/sft_decoder_bench.sv
module sft_decoder_bench;
  localparam int LEN = 12;
  localparam int W   = LEN * 4;
  localparam int SAT = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_sym = '0;
  logic       out_valid;
  logic [3:0] out_err;
  logic [2:0] out_info;

  sft_decoder #(.MW(6), .LEN_INT(LEN)) u_sft_decoder (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_sym (in_sym),
    .out_valid (out_valid), .out_err (out_err), .out_info (out_info)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int           mpm [8];
  logic [W-1:0] msv [8];
  int           due_q [$];
  logic [3:0]   exp_q [$];
  logic [3:0]   cwx_q [$];
  int           tag_q [$];
  logic [3:0]   cw_list [$];
  int           tag_list [$];
  int           kint;
  logic [2:0]   h1, h2;

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sadd(input int a, input int b);
    if (a >= SAT) return SAT;
    return (a + b > SAT) ? SAT : a + b;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      mpm[s] = (s == 0) ? 0 : SAT;
      msv[s] = '0;
    end
    kint = 0;
    cw_list.delete();
    tag_list.delete();
    h1 = '0;
    h2 = '0;
  endtask

  // behavioural search per R6, R7, R8, R9
  task automatic model_interval(input logic [3:0] c, output logic [3:0] o);
    int npm [8];
    logic [W-1:0] nsv [8];
    int mn;
    int sel;
    for (int j = 0; j < 4; j++) begin
      int m;
      m = 1 + (((j == 1) || (j == 3)) ? 2 : 0) + (((j == 2) || (j == 3)) ? 4 : 0);
      for (int t = 0; t < 8; t++) begin
        int a, cs, cf, p;
        logic eb;
        a  = t ^ m;
        cs = sadd(mpm[t], c[j] ? 1 : 0);
        cf = sadd(mpm[a], c[j] ? 0 : 1);
        if (cf < cs || (cf == cs && a < t)) begin p = a; eb = 1'b1; npm[t] = cf; end
        else begin p = t; eb = 1'b0; npm[t] = cs; end
        nsv[t] = {msv[p][W-2:0], eb};
      end
      for (int t = 0; t < 8; t++) begin mpm[t] = npm[t]; msv[t] = nsv[t]; end
    end
    for (int n = 0; n < 8; n++) begin
      npm[n] = (n >= 4) ? SAT : mpm[n * 2];
      nsv[n] = msv[(n % 4) * 2];
    end
    mn = npm[0];
    for (int n = 1; n < 8; n++) if (npm[n] < mn) mn = npm[n];
    for (int n = 0; n < 8; n++) begin
      mpm[n] = (npm[n] >= SAT) ? SAT : npm[n] - mn;
      msv[n] = nsv[n];
    end
    sel = 0;
    for (int n = 1; n < 8; n++) if (mpm[n] < mpm[sel]) sel = n;
    for (int j = 0; j < 4; j++) o[j] = msv[sel][W-1-j];
  endtask

  // systematic encoder per R4
  function automatic logic [3:0] encode(input logic [2:0] u);
    logic chk;
    chk = u[0] ^ h1[0] ^ u[1] ^ h2[1] ^ u[2] ^ h1[2] ^ h2[2];
    h2 = h1;
    h1 = u;
    return {u, chk};
  endfunction

  task automatic send(input logic [3:0] c, input logic [3:0] cw, input int tag, input int gap);
    logic [3:0] o;
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = c;
    model_interval(c, o);
    due_q.push_back(cyc + 6);
    exp_q.push_back(o);
    cw_list.push_back(cw);
    tag_list.push_back(tag);
    if (kint < LEN - 1) begin
      cwx_q.push_back(4'd0);
      tag_q.push_back(10);
    end else begin
      cwx_q.push_back(cw_list[kint - (LEN - 1)]);
      tag_q.push_back(tag_list[kint - (LEN - 1)]);
    end
    kint++;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  // output monitor, falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        int tg;
        logic [3:0] e, cx;
        void'(due_q.pop_front());
        e  = exp_q.pop_front();
        cx = cwx_q.pop_front();
        tg = tag_q.pop_front();
        check("R3", int'(out_valid), 1, "strobe on due cycle");
        if (tg == 2) check("R2 R6 R7 R8", int'(out_err), int'(e), "search result, varied spacing");
        else         check("R6 R7 R8", int'(out_err), int'(e), "search result");
        check("R9", int'(out_info), int'(e[3:1]), "info bits");
        case (tg)
          4:  check("R4", int'(out_err), int'(cx), "clean code sequence");
          5:  check("R5", int'(out_err), int'(cx), "single error removed");
          10: check("R10", int'(out_err), 0, "empty survivor after reset");
          default: ;
        endcase
      end else if (out_valid) begin
        total++;
        bad++;
        $display("FAIL R3 unexpected strobe act=1 exp=0");
      end
    end
  end

  task automatic reset_checks();
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(out_err), 0, "out_err in reset");
    check("R1", int'(out_info), 0, "out_info in reset");
  endtask

  initial begin
    logic [3:0] cw, c;
    logic [2:0] u;
    model_reset();
    repeat (4) @(negedge clk);
    reset_checks();
    rst = 1'b0;

    // clean code sequence
    for (int i = 0; i < 20; i++) begin
      u  = 3'($urandom);
      cw = encode(u);
      send(cw, cw, 4, 4);
    end

    // isolated single errors
    for (int i = 0; i < 48; i++) begin
      u  = 3'($urandom);
      cw = encode(u);
      c  = cw;
      if (i == 2 || i == 18 || i == 34) c = c ^ (4'b0001 << ($urandom % 4));
      send(c, cw, (i < 36) ? 5 : 0, 5);
    end

    // arbitrary symbols, alternating spacing
    for (int i = 0; i < 40; i++) begin
      c = (i % 9 == 0) ? 4'hF : 4'($urandom);
      send(c, 4'd0, 2, (i % 2 == 1) ? 7 : 4);
    end

    // reset during operation and restart
    repeat (10) @(negedge clk);
    rst = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    reset_checks();
    check("R1", due_q.size(), 0, "no result pending");
    rst = 1'b0;
    for (int i = 0; i < 18; i++) begin
      u  = 3'($urandom);
      cw = encode(u);
      send(cw, cw, 4, 4);
    end
    repeat (10) @(negedge clk);
    check("R3", due_q.size(), 0, "all results delivered");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule